// File: doc/BRIEF.md
# Hint-Aware LRU Tag Store

A small fully associative tag store whose replacement order follows a one-bit hint that comes with each lookup. A lookup is either normal or streaming (non-temporal). Normal lookups keep the usual least-recently-used order. Streaming lookups never move a line toward the most-recently-used end. A streaming miss places its line at the least-recently-used end, so a run of streaming misses keeps replacing one way and leaves lines that are reused in time where they are.

Each lookup presents a tag and the hint. One clock edge later the block reports the result:
- whether the lookup hit;
- the way that was used;
- whether a valid line was evicted, and if so its tag.

Only tags, valid bits and recency state are held. Data, refill, write-back and coherence belong to the surrounding logic.

Top module: `hint_lru_tags`

## Requirements
- R1: A lookup hits exactly when its tag equals the tag of a valid way; on a hit the reported way is that way and no eviction is reported.
- R2: The result of a lookup appears on the outputs at the first rising clock edge after the cycle in which `req_valid_i` is high. `rsp_valid_o` is high for exactly that one cycle. With `req_valid_i` low, the tags, valid bits and recency order do not change.
- R3: A normal lookup (`req_nt_i` = 0), whether it hits or fills, makes the way it used the most recently used. Every way that was more recent moves one step older.
- R4: A streaming lookup (`req_nt_i` = 1) that hits leaves the recency order unchanged.
- R5: A streaming miss fills the victim way and leaves that way least recently used. A following miss with all ways valid therefore evicts that same way again.
- R6: While any way is invalid, a miss fills the invalid way with the lowest index and reports no eviction (`rsp_evict_valid_o` = 0).
- R7: When all ways are valid, a miss fills the least recently used way. It reports `rsp_evict_valid_o` = 1 and the old tag of that way on `rsp_evict_tag_o`.
- R8: Reset (`rst_ni` low) clears every valid bit and sets the recency order so that way i has age i (age 0 is most recent). After reset the first misses fill ways 0, 1, 2, … in turn.
- R9: A stream of streaming misses into a full store never evicts a line that was last touched by a normal lookup, as long as at least one way holds a line filled by a streaming miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_tag_i | input | TAG_W | Tag to look up |
| req_nt_i | input | 1 | Hint: 0 normal, 1 streaming |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_way_o | output | $clog2(WAYS) | Way hit or filled |
| rsp_evict_valid_o | output | 1 | A valid line was replaced |
| rsp_evict_tag_o | output | TAG_W | Tag of the replaced line |

## Verification
The hardest state to reach from the ports is a full store with a mix of streaming and normal lines, where the least recently used way holds a streaming line and a recently reused normal line sits next to it. Only an eviction shows the order, so a wrong demotion stays hidden until the next miss. The stimulus first fills every way with normal lookups. It then issues streaming misses and streaming hits between normal re-touches, so each eviction reveals the order. A long pseudo-random sweep over a tag space twice the number of ways follows. It mixes hints, idle gaps and back-to-back lookups, and every response is compared against an arithmetic recency model.

// File: rtl/hlru_pkg.sv
package hlru_pkg;
  typedef enum logic {
    HINT_NORMAL = 1'b0,
    HINT_STREAM = 1'b1
  } hint_e;
endpackage

// File: rtl/hlru_match.sv
module hlru_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            match_o,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           hit_way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_o[w]) hit_way_o = IDX_W'(w);
    end
  end
endmodule

// File: rtl/hlru_victim.sv
module hlru_victim #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][IDX_W-1:0] ages_i,
  output logic [IDX_W-1:0]           victim_o
);
  localparam logic [IDX_W-1:0] LastAge = IDX_W'(WAYS - 1);

  logic [IDX_W-1:0] lru_way, inv_way;

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ages_i[w] == LastAge) lru_way = IDX_W'(w);
    end
  end

  // descending scan so the lowest invalid index wins
  always_comb begin
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) inv_way = IDX_W'(w);
    end
  end

  assign victim_o = (&valid_i) ? lru_way : inv_way;
endmodule

// File: rtl/hlru_age.sv
module hlru_age #(
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       upd_i,
  input  logic [IDX_W-1:0]           way_i,
  input  logic                       to_lru_i,
  output logic [WAYS-1:0][IDX_W-1:0] ages_o
);
  localparam logic [IDX_W-1:0] LastAge = IDX_W'(WAYS - 1);

  logic [WAYS-1:0][IDX_W-1:0] ages_q, ages_d;
  logic [IDX_W-1:0]           ref_age;

  assign ref_age = ages_q[way_i];

  always_comb begin
    ages_d = ages_q;
    if (upd_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (IDX_W'(w) == way_i) begin
          ages_d[w] = to_lru_i ? LastAge : '0;
        end else if (!to_lru_i && ages_q[w] < ref_age) begin
          ages_d[w] = ages_q[w] + 1'b1;
        end else if (to_lru_i && ages_q[w] > ref_age) begin
          ages_d[w] = ages_q[w] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++) ages_q[w] <= IDX_W'(w);
    end else begin
      ages_q <= ages_d;
    end
  end

  assign ages_o = ages_q;

  // ages form a permutation of 0..WAYS-1
  for (genvar k = 0; k < WAYS; k++) begin : g_perm
    logic [WAYS-1:0] holders;
    for (genvar w = 0; w < WAYS; w++) begin : g_h
      assign holders[w] = (ages_q[w] == IDX_W'(k));
    end
    p_age_perm_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(holders) == 1);
  end

  p_promote_mru_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !to_lru_i |=> ages_q[$past(way_i)] == '0);

  p_stream_lru_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && to_lru_i |=> ages_q[$past(way_i)] == LastAge);

  p_hold_order_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(ages_q));
endmodule

// File: rtl/hint_lru_tags.sv
module hint_lru_tags #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             req_nt_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [IDX_W-1:0] rsp_way_o,
  output logic             rsp_evict_valid_o,
  output logic [TAG_W-1:0] rsp_evict_tag_o
);
  import hlru_pkg::*;

  logic [WAYS-1:0][TAG_W-1:0] tags_q;
  logic [WAYS-1:0]            valid_q;
  logic [WAYS-1:0][IDX_W-1:0] ages;
  logic [WAYS-1:0]            match;
  logic                       hit;
  logic [IDX_W-1:0]           hit_way, victim, sel_way;
  logic                       age_upd;
  hint_e                      hint;

  assign hint = hint_e'(req_nt_i);

  hlru_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags_i   (tags_q),
    .valid_i  (valid_q),
    .tag_i    (req_tag_i),
    .match_o  (match),
    .hit_o    (hit),
    .hit_way_o(hit_way)
  );

  hlru_victim #(.WAYS(WAYS)) u_victim (
    .valid_i (valid_q),
    .ages_i  (ages),
    .victim_o(victim)
  );

  assign sel_way = hit ? hit_way : victim;
  // a streaming hit leaves the order alone
  assign age_upd = req_valid_i && !(hit && hint == HINT_STREAM);

  hlru_age #(.WAYS(WAYS)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (age_upd),
    .way_i   (sel_way),
    .to_lru_i(hint == HINT_STREAM),
    .ages_o  (ages)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tags_q            <= '0;
      valid_q           <= '0;
      rsp_valid_o       <= 1'b0;
      rsp_hit_o         <= 1'b0;
      rsp_way_o         <= '0;
      rsp_evict_valid_o <= 1'b0;
      rsp_evict_tag_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o         <= hit;
        rsp_way_o         <= sel_way;
        rsp_evict_valid_o <= !hit && valid_q[sel_way];
        rsp_evict_tag_o   <= tags_q[sel_way];
        if (!hit) begin
          tags_q[sel_way]  <= req_tag_i;
          valid_q[sel_way] <= 1'b1;
        end
      end
    end
  end

  p_unique_tag_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  p_hit_no_evict_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> !rsp_evict_valid_o);

  p_rsp_next_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_rsp_idle_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && $stable(valid_q) && $stable(tags_q));

  p_fill_invalid_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !hit && !(&valid_q) |-> !valid_q[victim]);

  p_evict_full_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !hit && (&valid_q) |=> rsp_evict_valid_o);
endmodule

// File: tb/tb_hint_lru_tags.sv
module tb_hint_lru_tags;
  localparam int WAYS  = 4;
  localparam int TAG_W = 8;
  localparam int IDX_W = $clog2(WAYS);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic [TAG_W-1:0] req_tag_i = '0;
  logic             req_nt_i = 1'b0;
  logic             rsp_valid_o, rsp_hit_o, rsp_evict_valid_o;
  logic [IDX_W-1:0] rsp_way_o;
  logic [TAG_W-1:0] rsp_evict_tag_o;

  int compared = 0;
  int mismatched = 0;

  // model state
  logic [TAG_W-1:0] m_tag [WAYS];
  bit               m_val [WAYS];
  int               m_age [WAYS];

  always #10 clk = ~clk;  // 50 MHz

  hint_lru_tags #(.WAYS(WAYS), .TAG_W(TAG_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_tag_i(req_tag_i), .req_nt_i(req_nt_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_way_o(rsp_way_o),
    .rsp_evict_valid_o(rsp_evict_valid_o), .rsp_evict_tag_o(rsp_evict_tag_o)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < WAYS; w++) begin
      m_val[w] = 0; m_tag[w] = '0; m_age[w] = w;
    end
  endtask

  task automatic model_access(input logic [TAG_W-1:0] t, input bit nt,
                              output bit eh, output int ew, output bit ev,
                              output logic [TAG_W-1:0] et);
    int ref_a;
    eh = 0; ew = 0; ev = 0; et = '0;
    for (int w = 0; w < WAYS; w++) if (m_val[w] && m_tag[w] == t) begin eh = 1; ew = w; end
    if (!eh) begin
      ew = -1;
      for (int w = 0; w < WAYS; w++) if (!m_val[w] && ew < 0) ew = w;
      if (ew < 0) for (int w = 0; w < WAYS; w++) if (m_age[w] == WAYS - 1) ew = w;
      ev = m_val[ew]; et = m_tag[ew];
      m_val[ew] = 1; m_tag[ew] = t;
    end
    ref_a = m_age[ew];
    if (!nt) begin
      for (int w = 0; w < WAYS; w++) if (m_age[w] < ref_a) m_age[w]++;
      m_age[ew] = 0;
    end else if (!eh) begin
      for (int w = 0; w < WAYS; w++) if (m_age[w] > ref_a) m_age[w]--;
      m_age[ew] = WAYS - 1;
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic access(input logic [TAG_W-1:0] t, input bit nt, input string rq_in);
    bit eh, ev; int ew; logic [TAG_W-1:0] et; string rq;
    model_access(t, nt, eh, ew, ev, et);
    req_valid_i = 1'b1; req_tag_i = t; req_nt_i = nt;
    @(negedge clk);
    req_valid_i = 1'b0;
    rq = (rq_in != "") ? rq_in : (eh ? "R1" : (ev ? "R7" : "R6"));
    chk(rsp_valid_o == 1'b1, "R2", "rsp_valid", rsp_valid_o, 1);
    chk(rsp_hit_o == eh && rsp_way_o == IDX_W'(ew) && rsp_evict_valid_o == ev &&
        (!ev || rsp_evict_tag_o == et), rq, "hit/way/ev/evtag",
        {rsp_hit_o, 4'(rsp_way_o), rsp_evict_valid_o, rsp_evict_tag_o},
        {eh, 4'(ew), ev, et});
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    // R8: reset state at the ports
    chk(rsp_valid_o == 0 && rsp_hit_o == 0 && rsp_evict_valid_o == 0, "R8",
        "reset outputs", {rsp_valid_o, rsp_hit_o, rsp_evict_valid_o}, 0);
    // R8/R6: first misses fill ways in ascending order, no eviction
    access(8'h10, 0, "R8");
    access(8'h11, 0, "R8");
    access(8'h12, 0, "R6");
    access(8'h13, 0, "R6");
    // R2: idle cycle, no response
    @(negedge clk);
    chk(rsp_valid_o == 0, "R2", "idle rsp_valid", rsp_valid_o, 0);
    // R7: normal miss in full store evicts LRU (way 0, tag 10)
    access(8'h20, 0, "R7");
    // R3: normal hit on 11 promotes it
    access(8'h11, 0, "R3");
    // R5: streaming misses keep replacing one way
    access(8'h30, 1, "R5");
    access(8'h31, 1, "R5");
    access(8'h32, 1, "R5");
    // R4: streaming hit leaves order; next streaming miss evicts it again
    access(8'h32, 1, "R4");
    access(8'h33, 1, "R4");
    // R9: normal lines all still hit
    access(8'h11, 0, "R9");
    access(8'h20, 0, "R9");
    access(8'h13, 0, "R9");
    // R6: streaming fill into invalid way after reset, then normal fills
    do_reset();
    access(8'h40, 1, "R6");
    access(8'h41, 0, "R6");
    access(8'h42, 1, "R6");
    access(8'h43, 0, "R6");
    access(8'h44, 0, "R7");
    access(8'h45, 1, "R5");
    // sweep: mixed hints, gaps, back-to-back
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      logic [TAG_W-1:0] t;
      bit nt;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      t  = TAG_W'(lfsr[2:0]);
      nt = (lfsr[5:4] == 2'b00);
      access(t, nt, "");
      if (lfsr[9:7] == 3'b000) begin
        @(negedge clk);
        chk(rsp_valid_o == 0, "R2", "gap rsp_valid", rsp_valid_o, 0);
      end
    end
    summary();
    $finish;
  end
endmodule